// File: doc/BRIEF.md
# Serial Bus Master Frame Engine

This block is the controller-side master of a shared serial line that reaches several power-stage devices. On one request it runs one complete transaction frame. The frame carries a target device number, a register number and a direction bit, then an acknowledge slot for the address. It continues with a data byte and a second acknowledge slot, and ends with a stop bit. Device number 0 is the broadcast number used for configuration writes, and it travels on the line like any other number. Writes send the byte. Reads release the line so that the addressed device can return the byte, which is handed back on the response port.

The bit rate comes from a divider value. A value N gives a bit period of 4·(N+1) system clocks, split into four equal phases. The line is sampled at the end of the second phase, which is the middle of the bit. The pin side uses separate paths: a drive enable, a drive value and a sampled input. A released line is pulled high outside the block, and a device acknowledges by pulling it low.

States are IDLE, START, DEV (device number), REG (register number), RW, AACK (address acknowledge), DATA, DACK (data acknowledge) and STOP. The transitions are:
- IDLE→START on an accepted request.
- START→DEV, DEV→REG and REG→RW at bit ends, with DEV and REG moving on after their last field bit.
- RW→AACK.
- AACK→DATA when the acknowledge was seen, and AACK→STOP when it was not.
- DATA→DACK after the last data bit.
- DACK→STOP.
- STOP→IDLE, which raises done.

Top module: `sbus_frame_master`

## Requirements
- R1: Bits leave in this order: start, device number (5 bits), register number (5 bits), direction, address acknowledge, data (8 bits), data acknowledge, stop. Every field goes most significant bit first, and the direction bit is 1 for a read and 0 for a write.
- R2: Each bit lasts 4·(clk_div+1) clocks. The divider value is captured when the request is accepted, so later changes do not affect the running frame. A full frame is 23 bits long, counted from the edge that accepts the request to the edge that raises done.
- R3: The start bit is driven low and the stop bit is driven high. The line is released (sbus_oe = 0) while idle.
- R4: During the address acknowledge slot the line is released. rsp_adr_ack is 1 when the line read low at mid-bit.
- R5: When no address acknowledge arrives, the data bits and the data acknowledge slot are skipped, so the frame is 14 bits long. rsp_dat_ack then reads 0 and rsp_rdata reads 0.
- R6: On a read, the line is released for all 8 data bits. Each bit is sampled at mid-bit and assembled most significant first into rsp_rdata, and the master itself drives the data acknowledge slot low, so rsp_dat_ack reads 1.
- R7: On a write, the line is released in the data acknowledge slot. rsp_dat_ack reports whether it read low, separately from rsp_adr_ack.
- R8: A request raised while a frame is running is ignored. The frame on the line and its length are unchanged.
- R9: done is high for exactly one clock after the stop bit ends. The response fields keep their values while idle until the next accepted request clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | 1 | Start a frame (taken only while idle) |
| req_dev | input | 5 | Target device number, 0 = broadcast |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 8 | Byte to write |
| req_read | input | 1 | 1 = read, 0 = write |
| clk_div | input | 8 | Bit-period divider N, period 4·(N+1) clocks |
| done | output | 1 | One-clock pulse at frame end |
| rsp_rdata | output | 8 | Byte returned by a read |
| rsp_adr_ack | output | 1 | Address acknowledge seen |
| rsp_dat_ack | output | 1 | Data acknowledge seen |
| sbus_oe | output | 1 | Line drive enable |
| sbus_do | output | 1 | Line drive value |
| sbus_di | input | 1 | Sampled line level |

## Verification
The assertions check several rules on every clock:
- the phase counter wraps correctly at the end of each bit;
- done never lasts two cycles, and it is always preceded by a driven-high stop bit;
- a missing address acknowledge always leads straight to STOP;
- the line is released throughout read data;
- the latched request does not move during a frame;
- the response fields stay still while idle.

Other properties can only be shown by the bench's scenarios, which play a device model against the line. These are the exact bit order and field contents seen on the wire, the frame length in clocks for each divider value, the byte assembled from a read, and the separate reporting of address and data acknowledges.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEV,
        ST_REG,
        ST_RW,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_STOP
    } sbus_state_e;

    localparam int PHASES_PER_BIT = 4;

endpackage

// File: rtl/sbus_bit_timer.sv
module sbus_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sample_pt,
    output logic             bit_end
);
    import sbus_pkg::*;

    localparam int PH_W = $clog2(PHASES_PER_BIT);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(PHASES_PER_BIT / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES_PER_BIT - 1);

    logic [DIV_W-1:0] cnt;
    logic [PH_W-1:0]  phase;
    logic             slot_end;

    assign slot_end = (cnt == div);

    // Each phase lasts div+1 clocks; four phases make one bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= '0;
        end else if (!run) begin
            cnt   <= '0;
            phase <= '0;
        end else if (slot_end) begin
            cnt   <= '0;
            phase <= phase + 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign sample_pt = run && slot_end && (phase == PH_MID);
    assign bit_end   = run && slot_end && (phase == PH_LAST);

    // R2: the divider is held for the frame, so the count never passes it
    always @(posedge clk) begin
        if (rst_n) begin
            assert_cnt_bound_R2: assert (cnt <= div)
                else $error("phase counter passed divider");
        end
    end

    // R2: a bit end always restarts the next bit at phase 0, count 0
    assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (phase == '0 && cnt == '0));

endmodule

// File: rtl/sbus_frame_fsm.sv
module sbus_frame_fsm #(
    parameter int ID_W  = 5,
    parameter int ADR_W = 5,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [ID_W-1:0]  dev,
    input  logic [ADR_W-1:0] regno,
    input  logic [DAT_W-1:0] wdata,
    input  logic             rd_req,
    input  logic             sample_pt,
    input  logic             bit_end,
    input  logic             line_in,
    output logic             busy,
    output logic             done,
    output logic [DAT_W-1:0] rdata,
    output logic             adr_ack,
    output logic             dat_ack,
    output logic             line_oe,
    output logic             line_do
);
    import sbus_pkg::*;

    localparam int MAXW = (ID_W > ADR_W) ? ((ID_W > DAT_W) ? ID_W : DAT_W)
                                         : ((ADR_W > DAT_W) ? ADR_W : DAT_W);
    localparam int IW = (MAXW > 1) ? $clog2(MAXW) : 1;

    sbus_state_e      state;
    logic [IW-1:0]    idx;
    logic [ID_W-1:0]  dev_q;
    logic [ADR_W-1:0] reg_q;
    logic [DAT_W-1:0] wd_q;
    logic             rd_q;
    logic [DAT_W-1:0] rx_q;
    logic             aack_q;
    logic             dack_q;
    logic             last_idx;

    assign last_idx = (idx == '0);
    assign busy     = (state != ST_IDLE);

    // State register, field index, latched request and captured status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            dev_q  <= '0;
            reg_q  <= '0;
            wd_q   <= '0;
            rd_q   <= 1'b0;
            rx_q   <= '0;
            aack_q <= 1'b0;
            dack_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        state  <= ST_START;
                        dev_q  <= dev;
                        reg_q  <= regno;
                        wd_q   <= wdata;
                        rd_q   <= rd_req;
                        rx_q   <= '0;
                        aack_q <= 1'b0;
                        dack_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state <= ST_DEV;
                        idx   <= IW'(ID_W - 1);
                    end
                end
                ST_DEV: begin
                    if (bit_end) begin
                        if (last_idx) begin
                            state <= ST_REG;
                            idx   <= IW'(ADR_W - 1);
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                ST_REG: begin
                    if (bit_end) begin
                        if (last_idx) begin
                            state <= ST_RW;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                ST_RW: begin
                    if (bit_end) begin
                        state <= ST_AACK;
                    end
                end
                ST_AACK: begin
                    if (sample_pt) begin
                        aack_q <= !line_in;
                    end
                    if (bit_end) begin
                        if (aack_q) begin
                            state <= ST_DATA;
                            idx   <= IW'(DAT_W - 1);
                        end else begin
                            state <= ST_STOP;
                        end
                    end
                end
                ST_DATA: begin
                    if (sample_pt && rd_q) begin
                        rx_q <= {rx_q[DAT_W-2:0], line_in};
                    end
                    if (bit_end) begin
                        if (last_idx) begin
                            state <= ST_DACK;
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                end
                ST_DACK: begin
                    if (sample_pt) begin
                        dack_q <= !line_in;
                    end
                    if (bit_end) begin
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line drive per state
    always_comb begin
        line_oe = 1'b0;
        line_do = 1'b1;
        unique case (state)
            ST_IDLE:  begin line_oe = 1'b0; line_do = 1'b1; end
            ST_START: begin line_oe = 1'b1; line_do = 1'b0; end
            ST_DEV:   begin line_oe = 1'b1; line_do = dev_q[idx]; end
            ST_REG:   begin line_oe = 1'b1; line_do = reg_q[idx]; end
            ST_RW:    begin line_oe = 1'b1; line_do = rd_q; end
            ST_AACK:  begin line_oe = 1'b0; line_do = 1'b1; end
            ST_DATA:  begin line_oe = !rd_q; line_do = wd_q[idx]; end
            ST_DACK:  begin line_oe = rd_q;  line_do = 1'b0; end
            ST_STOP:  begin line_oe = 1'b1; line_do = 1'b1; end
            default:  begin line_oe = 1'b0; line_do = 1'b1; end
        endcase
    end

    assign rdata   = rx_q;
    assign adr_ack = aack_q;
    assign dat_ack = dack_q;

    // R9: done never lasts two clocks
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done is always preceded by a driven-high stop bit
    assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(line_oe && line_do));

    // R5: missing address acknowledge leads straight to the stop bit
    assert_nack_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK && bit_end && !aack_q) |=> (state == ST_STOP));

    // R6: the line stays released during read data
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && rd_q) |-> !line_oe);

    // R8: the latched request does not move while a frame runs
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dev_q) && $stable(reg_q) && $stable(wd_q) && $stable(rd_q)));

    // R9: response fields hold while idle without a request
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> ($stable(rx_q) && $stable(aack_q) && $stable(dack_q)));

endmodule

// File: rtl/sbus_frame_master.sv
module sbus_frame_master #(
    parameter int ID_W  = 5,
    parameter int ADR_W = 5,
    parameter int DAT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_go,
    input  logic [ID_W-1:0]  req_dev,
    input  logic [ADR_W-1:0] req_reg,
    input  logic [DAT_W-1:0] req_wdata,
    input  logic             req_read,
    input  logic [DIV_W-1:0] clk_div,
    output logic             done,
    output logic [DAT_W-1:0] rsp_rdata,
    output logic             rsp_adr_ack,
    output logic             rsp_dat_ack,
    output logic             sbus_oe,
    output logic             sbus_do,
    input  logic             sbus_di
);

    logic             busy;
    logic             sample_pt;
    logic             bit_end;
    logic [DIV_W-1:0] div_q;

    // Divider is captured at acceptance and held for the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (req_go && !busy) begin
            div_q <= clk_div;
        end
    end

    sbus_bit_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );

    sbus_frame_fsm #(
        .ID_W  (ID_W),
        .ADR_W (ADR_W),
        .DAT_W (DAT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (req_go),
        .dev       (req_dev),
        .regno     (req_reg),
        .wdata     (req_wdata),
        .rd_req    (req_read),
        .sample_pt (sample_pt),
        .bit_end   (bit_end),
        .line_in   (sbus_di),
        .busy      (busy),
        .done      (done),
        .rdata     (rsp_rdata),
        .adr_ack   (rsp_adr_ack),
        .dat_ack   (rsp_dat_ack),
        .line_oe   (sbus_oe),
        .line_do   (sbus_do)
    );

    // R2: divider copy is frozen while a frame runs
    assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_q));

endmodule

// File: tb/sim_sbus_frame_master.sv
module sim_sbus_frame_master;

    localparam int CLK_PERIOD = 10;
    localparam int FULL_BITS  = 23;
    localparam int SHORT_BITS = 14;

    logic       clk;
    logic       rst_n;
    logic       req_go;
    logic [4:0] req_dev;
    logic [4:0] req_reg;
    logic [7:0] req_wdata;
    logic       req_read;
    logic [7:0] clk_div;
    logic       done;
    logic [7:0] rsp_rdata;
    logic       rsp_adr_ack;
    logic       rsp_dat_ack;
    logic       sbus_oe;
    logic       sbus_do;
    logic       sbus_di;
    logic       slv_low;

    int n_chk  = 0;
    int n_fail = 0;

    // open-drain line with pull-up: master and device model
    assign sbus_di = (sbus_oe ? sbus_do : 1'b1) & ~slv_low;

    sbus_frame_master u0 (
        .clk (clk), .rst_n (rst_n), .req_go (req_go), .req_dev (req_dev),
        .req_reg (req_reg), .req_wdata (req_wdata), .req_read (req_read),
        .clk_div (clk_div), .done (done), .rsp_rdata (rsp_rdata),
        .rsp_adr_ack (rsp_adr_ack), .rsp_dat_ack (rsp_dat_ack),
        .sbus_oe (sbus_oe), .sbus_do (sbus_do), .sbus_di (sbus_di)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One frame against a device model: devices 0..3 answer, others are absent
    task automatic run_frame(input int n, input int id, input int adr, input int wd,
                             input bit rd, input bit dack_en, input bit glitch,
                             input bit hold_chk);
        bit       present;
        int       p;
        int       nbits;
        int       k;
        int       b;
        int       off;
        logic [7:0]  rd_byte;
        logic [10:0] hdr;
        logic [7:0]  rxd;
        logic        start_lv;
        logic        stop_lv;
        logic        aack_lv;
        logic [7:0]  s_rdata;
        logic        s_aack;
        logic        s_dack;
        present = (id <= 3);
        p       = 4 * (n + 1);
        nbits   = present ? FULL_BITS : SHORT_BITS;
        rd_byte = 8'((id * 29 + adr * 5 + 8'h5A) & 255);
        hdr = '0; rxd = '0; start_lv = 1'b1; stop_lv = 1'b0; aack_lv = 1'b0;

        @(negedge clk);
        req_dev = 5'(id); req_reg = 5'(adr); req_wdata = 8'(wd);
        req_read = rd; clk_div = 8'(n); req_go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_go  = 1'b0;
        clk_div = 8'(n + 5);        // R2: change after acceptance must not matter
        k = 0;
        forever begin
            b   = k / p;
            off = k % p;
            if (off == p / 2 - 1) begin
                if (b == 0) start_lv = sbus_di;
                if (b >= 1 && b <= 11) hdr = {hdr[9:0], sbus_di};
                if (b == 12) aack_lv = sbus_di;
                if (present && !rd && b >= 13 && b <= 20) rxd = {rxd[6:0], sbus_di};
                if (b == nbits - 1) stop_lv = sbus_di;
            end
            slv_low = present && ((b == 12) ||
                      (rd && b >= 13 && b <= 20 && !rd_byte[20 - b]) ||
                      (!rd && b == 21 && dack_en));
            if (glitch && k == 3 * p) begin
                req_go = 1'b1; req_dev = ~5'(id); req_read = ~rd; clk_div = 8'd0;
            end
            if (glitch && k == 3 * p + 1) req_go = 1'b0;
            @(posedge clk);
            k++;
            @(negedge clk);
            if (done || k > 5000) break;
        end
        slv_low = 1'b0;

        check(k == nbits * p, "R2", "frame clocks", k, nbits * p);
        check(start_lv == 1'b0, "R3", "start level", start_lv, 0);
        check(stop_lv == 1'b1, "R3", "stop level", stop_lv, 1);
        check(hdr == {5'(id), 5'(adr), rd}, "R1", "header bits", hdr, {5'(id), 5'(adr), rd});
        if (glitch) check(hdr == {5'(id), 5'(adr), rd}, "R8", "header under busy go", hdr,
                          {5'(id), 5'(adr), rd});
        check(rsp_adr_ack == present, "R4", "address ack", rsp_adr_ack, present);
        if (!present) begin
            check(aack_lv == 1'b1, "R4", "released ack slot level", aack_lv, 1);
            check(rsp_dat_ack == 1'b0, "R5", "data ack on nack", rsp_dat_ack, 0);
            check(rsp_rdata == 8'h00, "R5", "rdata on nack", rsp_rdata, 0);
        end else if (rd) begin
            check(rsp_rdata == rd_byte, "R6", "read byte", rsp_rdata, rd_byte);
            check(rsp_dat_ack == 1'b1, "R6", "master data ack", rsp_dat_ack, 1);
        end else begin
            check(rxd == 8'(wd), "R1", "write byte on line", rxd, wd);
            check(rsp_dat_ack == dack_en, "R7", "write data ack", rsp_dat_ack, dack_en);
        end
        s_rdata = rsp_rdata; s_aack = rsp_adr_ack; s_dack = rsp_dat_ack;
        @(negedge clk);
        check(done == 1'b0, "R9", "done width", done, 0);
        if (hold_chk) begin
            repeat (4) @(negedge clk);
            check(sbus_oe == 1'b0, "R3", "idle release", sbus_oe, 0);
            check({rsp_rdata, rsp_adr_ack, rsp_dat_ack} == {s_rdata, s_aack, s_dack},
                  "R9", "status hold", {rsp_rdata, rsp_adr_ack, rsp_dat_ack},
                  {s_rdata, s_aack, s_dack});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_go = 1'b0; req_dev = '0; req_reg = '0; req_wdata = '0;
        req_read = 1'b0; clk_div = '0; slv_low = 1'b0;
        repeat (3) @(negedge clk);
        check(sbus_oe == 1'b0, "R3", "reset release", sbus_oe, 0);
        check(done == 1'b0, "R9", "reset done", done, 0);
        check(rsp_adr_ack == 1'b0, "R4", "reset ack", rsp_adr_ack, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: divider 0..2, every device number, both directions
        for (int n = 0; n < 3; n++) begin
            for (int id = 0; id < 32; id++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    run_frame(n, id, (id * 3 + n + rd) % 32, (id * 37 + n * 11 + rd) & 255,
                              rd[0], 1'b1, 1'b0, 1'b0);
                end
            end
        end
        // R7: device withholds the data acknowledge on a write
        run_frame(1, 2, 9, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: request during a running frame, read and write
        run_frame(2, 1, 17, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0);
        run_frame(1, 3, 30, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
        // R2: slower divider, broadcast write and nack with hold check
        run_frame(7, 0, 31, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1);
        run_frame(5, 20, 0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule